// File: doc/BRIEF.md
# Test Vector Playback and Capture Engine

This block plays a stored sequence of 4-bit test words out at full clock rate and records what comes back. The host first sets a word count and writes the words into an on-chip playback buffer. Only once the whole set has arrived does a start command send them out, one word per clock. Each sent word carries a presence strobe, and the first one also carries a single-cycle trigger for an external scope. At the same time, any word returning with its own presence strobe is stored in a second on-chip buffer.

When nothing has come back for a fixed number of cycles after the last sent word, the engine moves to readback. The host then pulls the captured words out one read strobe at a time, and compares the capture count with the load count to spot lost words.

The state machine has four named states: IDLE, LOAD, RUN and READBACK. It has four named transitions:
- CONFIGURE takes IDLE to LOAD on a valid count.
- LAUNCH takes LOAD to RUN on start with the buffer full.
- DRAIN_DONE takes RUN to READBACK after the quiet window.
- RELEASE takes READBACK back to IDLE on a read strobe while empty.

Top module: `vec_loop_engine`

## Requirements
- R1: After reset, `state_o` is 0 (IDLE). `tx_present`, `tx_trigger`, `overflow`, `load_full` and `rd_empty` are 0, and `cap_count` is 0.
- R2: `state_o` encodes IDLE=0, LOAD=1, RUN=2, READBACK=3. In IDLE, `cfg_we` with `cfg_count` from 1 to 256 latches the count and enters LOAD. A count of 0 or above 256 is ignored, and the engine stays in IDLE.
- R3: In LOAD, each `wr_en` stores `wr_word` at the next position until the count is reached. A write beyond the count is discarded and is never transmitted. It sets `overflow`, which stays set until the next accepted configuration.
- R4: `start` is acted on only in LOAD with all words loaded. In any other state, or in LOAD before the count is reached, it has no effect.
- R5: After the clock edge that accepts `start`, the next edge raises `tx_present`. The loaded words then appear on `tx_word` in load order, one per cycle, exactly count words. After that, `tx_present` is 0.
- R6: `tx_trigger` is high for exactly one cycle, the same cycle as the first transmitted word.
- R7: In RUN, a word on `rx_word` is stored only on cycles with `rx_present` high, in arrival order. `cap_count` reports how many words were stored, so a short return shows as `cap_count` below the load count.
- R8: After the last word is sent, RUN ends after 16 consecutive cycles without `rx_present`. With no returns at all, READBACK is visible count+16 edges after the edge that accepted `start`.
- R9: In READBACK, each `rd_strobe` puts the next captured word on `rd_word` after the following edge. `rd_empty` is high exactly when all captured words have been read, and is high at once if none were captured.
- R10: A `rd_strobe` while `rd_empty` is high returns the engine to IDLE.
- R11: `load_full` is high in LOAD exactly when the number of stored words equals the configured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Count configuration write |
| cfg_count | input | 9 | Number of words to load (1..256) |
| wr_en | input | 1 | Host word write |
| wr_word | input | 4 | Word written by the host |
| start | input | 1 | Launch playback |
| tx_word | output | 4 | Transmitted word |
| tx_present | output | 1 | Transmitted word valid |
| tx_trigger | output | 1 | Scope trigger on first word |
| rx_word | input | 4 | Returning word |
| rx_present | input | 1 | Returning word valid |
| rd_strobe | input | 1 | Host read of next captured word |
| rd_word | output | 4 | Captured word read back |
| rd_empty | output | 1 | All captured words read |
| state_o | output | 2 | Current state encoding |
| load_full | output | 1 | Load count reached |
| overflow | output | 1 | Write beyond load count seen |
| cap_count | output | 9 | Number of captured words |

## Verification
All outputs are registered. A configuration, write or start shows on `state_o` and the flags one edge after the edge that samples it. The first transmitted word and the trigger appear one edge after the start edge, and a read strobe shows its word on `rd_word` one edge later. The bench drives inputs on the falling edge and samples on the following falling edge, so each result is read exactly one edge after its cause. The transmit stream is compared word by word at the cycle it is due. The quiet-window exit is checked by counting edges from the start edge to the first READBACK sample and comparing against count+16.

// File: rtl/vle_pkg.sv
package vle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD     = 2'd1,
        ST_RUN      = 2'd2,
        ST_READBACK = 2'd3
    } vle_state_e;
endpackage

// File: rtl/vle_word_buf.sv
// Single-write, asynchronous-read word store used for playback and capture.
module vle_word_buf #(
    parameter int W     = 4,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vle_seq.sv
// Sequencer: state machine, word counters, transmit and readback registers.
module vle_seq
    import vle_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 256,
    parameter int LAT   = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int QW   = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_count,
    input  logic          wr_en,
    input  logic          start,
    input  logic          rx_present,
    input  logic          rd_strobe,
    input  logic [W-1:0]  ld_rdata,
    input  logic [W-1:0]  cap_rdata,
    output logic          ld_we,
    output logic [AW-1:0] ld_waddr,
    output logic [AW-1:0] ld_raddr,
    output logic          cap_we,
    output logic [AW-1:0] cap_waddr,
    output logic [AW-1:0] cap_raddr,
    output logic [W-1:0]  tx_word,
    output logic          tx_present,
    output logic          tx_trigger,
    output logic [W-1:0]  rd_word,
    output logic          rd_empty,
    output logic [1:0]    state_o,
    output logic          load_full,
    output logic          overflow,
    output logic [CW-1:0] cap_count
);
    localparam logic [CW-1:0] DEPTH_C    = CW'(DEPTH);
    localparam logic [QW-1:0] QUIET_LAST = QW'(LAT - 1);

    vle_state_e    state_q, state_d;
    logic [CW-1:0] count_q, wr_ptr_q, tx_idx_q, cap_q, rd_ptr_q;
    logic [QW-1:0] quiet_q;
    logic          ovf_q, txp_q, trg_q;
    logic [W-1:0]  txw_q, rdw_q;

    logic cfg_ok, full, tx_done, cap_room, rb_empty;
    logic configure, launch, drain_done, release_rb;

    assign cfg_ok   = cfg_we && (cfg_count != '0) && (cfg_count <= DEPTH_C);
    assign full     = (wr_ptr_q == count_q);
    assign tx_done  = (tx_idx_q == count_q);
    assign cap_room = (cap_q != DEPTH_C);
    assign rb_empty = (rd_ptr_q == cap_q);

    assign configure  = (state_q == ST_IDLE) && cfg_ok;
    assign launch     = (state_q == ST_LOAD) && start && full;
    assign drain_done = (state_q == ST_RUN) && tx_done && !rx_present
                        && (quiet_q == QUIET_LAST);
    assign release_rb = (state_q == ST_READBACK) && rd_strobe && rb_empty;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (configure)  state_d = ST_LOAD;
            ST_LOAD:     if (launch)     state_d = ST_RUN;
            ST_RUN:      if (drain_done) state_d = ST_READBACK;
            ST_READBACK: if (release_rb) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Load-side counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            wr_ptr_q <= '0;
            ovf_q    <= 1'b0;
        end else if (configure) begin
            count_q  <= cfg_count;
            wr_ptr_q <= '0;
            ovf_q    <= 1'b0;
        end else if (state_q == ST_LOAD && wr_en) begin
            if (!full) wr_ptr_q <= wr_ptr_q + 1'b1;
            else       ovf_q    <= 1'b1;
        end
    end

    // Playback, quiet window and capture counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_idx_q <= '0;
            quiet_q  <= '0;
            cap_q    <= '0;
            txw_q    <= '0;
            txp_q    <= 1'b0;
            trg_q    <= 1'b0;
        end else if (launch) begin
            tx_idx_q <= '0;
            quiet_q  <= '0;
            cap_q    <= '0;
            txp_q    <= 1'b0;
            trg_q    <= 1'b0;
        end else if (state_q == ST_RUN) begin
            if (!tx_done) begin
                txw_q    <= ld_rdata;
                txp_q    <= 1'b1;
                trg_q    <= (tx_idx_q == '0);
                tx_idx_q <= tx_idx_q + 1'b1;
            end else begin
                txp_q <= 1'b0;
                trg_q <= 1'b0;
            end
            if (tx_done && !rx_present) quiet_q <= quiet_q + 1'b1;
            else                        quiet_q <= '0;
            if (cap_we) cap_q <= cap_q + 1'b1;
        end else begin
            txp_q <= 1'b0;
            trg_q <= 1'b0;
        end
    end

    // Readback pointer and output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            rdw_q    <= '0;
        end else if (drain_done) begin
            rd_ptr_q <= '0;
        end else if (state_q == ST_READBACK && rd_strobe && !rb_empty) begin
            rdw_q    <= cap_rdata;
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    assign ld_we     = (state_q == ST_LOAD) && wr_en && !full;
    assign ld_waddr  = wr_ptr_q[AW-1:0];
    assign ld_raddr  = tx_idx_q[AW-1:0];
    assign cap_we    = (state_q == ST_RUN) && rx_present && cap_room;
    assign cap_waddr = cap_q[AW-1:0];
    assign cap_raddr = rd_ptr_q[AW-1:0];

    assign tx_word    = txw_q;
    assign tx_present = txp_q;
    assign tx_trigger = trg_q;
    assign rd_word    = rdw_q;
    assign rd_empty   = (state_q == ST_READBACK) && rb_empty;
    assign state_o    = state_q;
    assign load_full  = (state_q == ST_LOAD) && full;
    assign overflow   = ovf_q;
    assign cap_count  = cap_q;
endmodule

// File: rtl/vec_loop_engine.sv
module vec_loop_engine #(
    parameter int WORD_W   = 4,
    parameter int DEPTH    = 256,
    parameter int RET_WAIT = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              start,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_present,
    output logic              tx_trigger,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_present,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_empty,
    output logic [1:0]        state_o,
    output logic              load_full,
    output logic              overflow,
    output logic [CNT_W-1:0]  cap_count
);
    logic              ld_we, cap_we;
    logic [AW-1:0]     ld_waddr, ld_raddr, cap_waddr, cap_raddr;
    logic [WORD_W-1:0] ld_rdata, cap_rdata;

    vle_word_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_play_buf (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_waddr),
        .wdata (wr_word),
        .raddr (ld_raddr),
        .rdata (ld_rdata)
    );

    vle_word_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_cap_buf (
        .clk   (clk),
        .we    (cap_we),
        .waddr (cap_waddr),
        .wdata (rx_word),
        .raddr (cap_raddr),
        .rdata (cap_rdata)
    );

    vle_seq #(.W(WORD_W), .DEPTH(DEPTH), .LAT(RET_WAIT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_count  (cfg_count),
        .wr_en      (wr_en),
        .start      (start),
        .rx_present (rx_present),
        .rd_strobe  (rd_strobe),
        .ld_rdata   (ld_rdata),
        .cap_rdata  (cap_rdata),
        .ld_we      (ld_we),
        .ld_waddr   (ld_waddr),
        .ld_raddr   (ld_raddr),
        .cap_we     (cap_we),
        .cap_waddr  (cap_waddr),
        .cap_raddr  (cap_raddr),
        .tx_word    (tx_word),
        .tx_present (tx_present),
        .tx_trigger (tx_trigger),
        .rd_word    (rd_word),
        .rd_empty   (rd_empty),
        .state_o    (state_o),
        .load_full  (load_full),
        .overflow   (overflow),
        .cap_count  (cap_count)
    );
endmodule

// File: rtl/vle_checks.sv
module vle_checks #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rx_present,
    input logic          rd_strobe,
    input logic          tx_present,
    input logic          tx_trigger,
    input logic          rd_empty,
    input logic [1:0]    state_o,
    input logic          load_full,
    input logic          overflow,
    input logic [CW-1:0] cap_count
);
    a_r6_trigger_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trigger |-> tx_present);

    a_r6_trigger_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trigger |=> !tx_trigger);

    a_r5_present_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        tx_present |-> (state_o == 2'd2));

    a_r4_start_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && start && !load_full) |=> (state_o == 2'd1));

    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && state_o != 2'd0) |=> overflow);

    a_r7_capture_needs_presence: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && !rx_present) |=> $stable(cap_count));

    a_r9_empty_in_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> (state_o == 2'd3));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && rd_strobe) |=> (state_o == 2'd0));
endmodule

bind vec_loop_engine vle_checks #(.CW($bits(cap_count))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rx_present (rx_present),
    .rd_strobe  (rd_strobe),
    .tx_present (tx_present),
    .tx_trigger (tx_trigger),
    .rd_empty   (rd_empty),
    .state_o    (state_o),
    .load_full  (load_full),
    .overflow   (overflow),
    .cap_count  (cap_count)
);

// File: tb/tb_vec_loop_engine.sv
`timescale 1ns/1ps
module tb_vec_loop_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_count = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_word = '0;
    logic       start = 1'b0;
    logic [3:0] tx_word;
    logic       tx_present, tx_trigger;
    logic [3:0] rx_word = '0;
    logic       rx_present = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [3:0] rd_word;
    logic       rd_empty;
    logic [1:0] state_o;
    logic       load_full, overflow;
    logic [8:0] cap_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vec_loop_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count(cfg_count),
        .wr_en(wr_en), .wr_word(wr_word), .start(start),
        .tx_word(tx_word), .tx_present(tx_present), .tx_trigger(tx_trigger),
        .rx_word(rx_word), .rx_present(rx_present), .rd_strobe(rd_strobe),
        .rd_word(rd_word), .rd_empty(rd_empty), .state_o(state_o),
        .load_full(load_full), .overflow(overflow), .cap_count(cap_count)
    );

    // Scenario table: {count[20:12], delay[11:8], drop period[7:4], seed[3:0]}
    localparam int NSCN = 5;
    localparam logic [20:0] SCN [NSCN] = '{
        {9'd5,   4'd0, 4'd0, 4'd3},
        {9'd1,   4'd2, 4'd0, 4'd7},
        {9'd16,  4'd9, 4'd3, 4'd5},
        {9'd256, 4'd4, 4'd0, 4'd9},
        {9'd12,  4'd1, 4'd2, 4'd11}
    };

    logic [3:0] exp_cap [256];
    int         n_exp;
    logic [4:0] pipe [16];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] word_of(input int i, input int seed);
        return 4'((i * seed + i / 3 + seed) & 15);
    endfunction

    task automatic do_cfg(input int n);
        cfg_count = 9'(n); cfg_we = 1'b1; tick(); cfg_we = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] w);
        wr_word = w; wr_en = 1'b1; tick(); wr_en = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    // Runs playback with a loopback of given delay; drop>0 loses every drop-th word.
    task automatic run_loop(input int n, input int seed, input int delay, input int drop,
                            input bit loop_on, output int edges);
        int idx = 0;
        n_exp = 0;
        edges = 0;
        for (int k = 0; k < 16; k++) pipe[k] = '0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            logic [4:0] ent;
            tick();
            edges++;
            ent = '0;
            if (tx_present) begin
                chk("R5 tx_word order", int'(tx_word), int'(word_of(idx, seed)));
                chk("R6 trigger with first word", int'(tx_trigger), (idx == 0) ? 1 : 0);
                if (loop_on && !(drop != 0 && (idx % drop) == drop - 1)) begin
                    ent = {1'b1, tx_word};
                    exp_cap[n_exp] = tx_word;
                    n_exp++;
                end
                idx++;
            end else begin
                chk("R6 no trigger without word", int'(tx_trigger), 0);
            end
            for (int k = 15; k > 0; k--) pipe[k] = pipe[k-1];
            pipe[0] = ent;
            rx_present = pipe[delay][4];
            rx_word    = loop_on ? pipe[delay][3:0] : 4'(cyc);
            if (state_o == 2'd3) break;
        end
        rx_present = 1'b0;
        chk("R5 number of words sent", idx, n);
    endtask

    task automatic readback_all(input string tag);
        chk({tag, " R7 cap_count"}, int'(cap_count), n_exp);
        chk({tag, " R9 empty at entry"}, int'(rd_empty), (n_exp == 0) ? 1 : 0);
        for (int j = 0; j < n_exp; j++) begin
            rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
            chk({tag, " R7 R9 rd_word"}, int'(rd_word), int'(exp_cap[j]));
            chk({tag, " R9 rd_empty"}, int'(rd_empty), (j == n_exp - 1) ? 1 : 0);
        end
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        chk({tag, " R10 back to IDLE"}, int'(state_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int edges;
        repeat (3) tick();
        // R1: reset state
        chk("R1 state", int'(state_o), 0);
        chk("R1 tx_present", int'(tx_present), 0);
        chk("R1 tx_trigger", int'(tx_trigger), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 load_full", int'(load_full), 0);
        chk("R1 rd_empty", int'(rd_empty), 0);
        chk("R1 cap_count", int'(cap_count), 0);
        rst_n = 1'b1;
        tick();

        // Table-driven scenarios
        for (int s = 0; s < NSCN; s++) begin
            int n     = int'(SCN[s][20:12]);
            int delay = int'(SCN[s][11:8]);
            int drop  = int'(SCN[s][7:4]);
            int seed  = int'(SCN[s][3:0]);
            do_cfg(n);
            chk("R2 enter LOAD", int'(state_o), 1);
            for (int i = 0; i < n; i++) do_write(word_of(i, seed));
            chk("R11 load_full", int'(load_full), 1);
            do_start();
            chk("R4 RUN after start", int'(state_o), 2);
            run_loop(n, seed, delay, drop, 1'b1, edges);
            chk("R8 reached READBACK", int'(state_o), 3);
            readback_all("table");
        end

        // R2: invalid counts ignored; R4: start in IDLE ignored
        do_cfg(0);
        chk("R2 count 0 ignored", int'(state_o), 0);
        do_cfg(257);
        chk("R2 count 257 ignored", int'(state_o), 0);
        do_start();
        chk("R4 start in IDLE ignored", int'(state_o), 0);
        chk("R4 no word from IDLE start", int'(tx_present), 0);

        // Partial load, early start, overflow, no return
        do_cfg(3);
        chk("R11 load_full empty", int'(load_full), 0);
        do_write(word_of(0, 6));
        do_write(word_of(1, 6));
        do_start();
        chk("R4 early start ignored", int'(state_o), 1);
        chk("R11 load_full partial", int'(load_full), 0);
        do_write(word_of(2, 6));
        chk("R11 load_full reached", int'(load_full), 1);
        chk("R3 no overflow yet", int'(overflow), 0);
        do_write(4'hF);
        chk("R3 overflow set", int'(overflow), 1);
        chk("R3 still full", int'(load_full), 1);
        do_start();
        chk("R3 overflow held in RUN", int'(overflow), 1);
        run_loop(3, 6, 0, 0, 1'b0, edges);
        chk("R8 quiet window edges", edges, 3 + 16);
        chk("R7 garbage without presence not stored", int'(cap_count), 0);
        chk("R9 empty at once with no capture", int'(rd_empty), 1);
        rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
        chk("R10 release to IDLE", int'(state_o), 0);
        do_cfg(2);
        chk("R3 overflow cleared by config", int'(overflow), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule